// File: doc/BRIEF.md
# Fractional-N Synthesizer Divider Chain

This block holds the digital counters of a fractional-N frequency synthesizer. It has two parts. The first is a programmable reference divider. It runs on the reference clock and produces the phase-comparison pulse. The second is a main feedback divider. It runs on the output clock of an external dual-modulus prescaler, which divides by 4 or by 5.

The main divider drives a swallow line. That line holds the prescaler at divide-by-5 for the first A prescaler periods of each main period. This gives a whole-loop ratio of 4·N + A.

A fractional accumulator of K bits adds a programmed word F once per main period. In any main period where the accumulator wraps, the integer count N of that period rises by one. The average ratio therefore carries a fractional part of F/2^K.

Configuration arrives as plain input words. Each divider captures its settings only at its own terminal count. A reprogramming step therefore completes the period in progress unchanged. Each output pulse comes from a register and is high for one clock.

Top module: `fracn_divider_chain`

## Requirements
- R1: With a limit value L from 0 to 128 on `cfg_r`, `ref_pulse_o` rises once every L+1 reference clocks. It is high for one clock, or stays high when L = 0.
- R2: A `cfg_r` value above 128 behaves exactly as 128, giving a reference period of 129 clocks.
- R3: With F = 0 and `cfg_n` from 3 to 1022, `fb_pulse_o` rises once every `cfg_n` feedback clocks and is high for one clock.
- R4: A `cfg_n` value of 0, 1 or 2 behaves as 3, and a value of 1023 behaves as 1022.
- R5: Number the feedback clocks of a main period 0, 1, 2, …, where clock 0 is the one in which `fb_pulse_o` is high. `mod5_o` is 1 exactly in clocks whose index is below A (`cfg_a`, range 0 to 3). The prescaler input count per period is therefore 4·N + A.
- R6: With K = width of `cfg_frac`, every run of 2^K consecutive main periods spans 2^K·N + F feedback clocks in total. Each single period lasts N or N+1 clocks.
- R7: A change of `cfg_r`, `cfg_n`, `cfg_a` or `cfg_frac` leaves the period in progress unchanged. The change applies from the period that starts after the next terminal count.
- R8: While `rst` is high, both pulse outputs are 0. In the first feedback clock after reset is released, `mod5_o` equals (A ≠ 0). The first `fb_pulse_o` appears N clocks after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| fb_clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| cfg_r | input | 8 | Reference limit value L (divide by L+1) |
| cfg_n | input | 10 | Main divider integer count N |
| cfg_a | input | 2 | Swallow count A (prescaler periods at divide-by-5) |
| cfg_frac | input | 8 | Fractional word F (K = 8 by default) |
| ref_pulse_o | output | 1 | Divided reference pulse |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| mod5_o | output | 1 | Prescaler modulus select, 1 = divide by 5 |

## Verification
The bench builds the block with a 4-bit fractional word, so K = 4. The default widths are kept for R, N and A. This makes one complete accumulator cycle only 16 main periods long. Every fractional word from 0 to 15 can then be swept, and the wrap count over each 16-period window can be checked arithmetically. The bench also sweeps every swallow count and the clamp values at both ends of the R and N ranges. It reprograms each divider exactly at a pulse, to show that the period already in progress keeps its old length.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Saturate an unsigned setting into a legal window.
  function automatic int unsigned clamp_range(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/fracn_ref_div.sv
module fracn_ref_div
  import fracn_pkg::*;
#(
  parameter int R_W   = 8,
  parameter int R_MAX = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] cfg_r,
  output logic           pulse_o
);

  logic [R_W-1:0] cnt_q;
  logic [R_W-1:0] lim_q;
  logic [R_W-1:0] lim_legal;
  logic           tc;

  always_comb begin
    lim_legal = R_W'(clamp_range(32'(cfg_r), 0, R_MAX));
    tc        = (cnt_q == lim_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lim_q   <= lim_legal;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tc;
      if (tc) begin
        cnt_q <= '0;
        lim_q <= lim_legal;
      end else begin
        cnt_q <= cnt_q + R_W'(1);
      end
    end
  end

  AST_REF_LIMIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    32'(lim_q) <= R_MAX); // R2
  AST_REF_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tc |=> $stable(lim_q)); // R7
  AST_REF_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_q); // R1

endmodule

// File: rtl/fracn_frac_acc.sv
module fracn_frac_acc #(
  parameter int F_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic [F_W-1:0] frac_i,
  output logic           carry_o
);

  logic [F_W-1:0] acc_q;
  logic [F_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_i};
    carry_o = sum[F_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= sum[F_W-1:0];
    end
  end

  AST_ACC_WRAP_DROPS: assert property (@(posedge clk) disable iff (rst)
    (step_i && carry_o) |=> (acc_q < $past(acc_q))); // R6
  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(acc_q)); // R7

endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fracn_pkg::*;
#(
  parameter int N_W   = 10,
  parameter int A_W   = 2,
  parameter int N_MIN = 3,
  parameter int N_MAX = 1022
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic           carry_i,
  output logic           tc_o,
  output logic           pulse_o,
  output logic           mod5_o
);

  localparam int PAD_W = N_W - A_W;

  logic [N_W-1:0] pos_q;
  logic [N_W-1:0] n_q;
  logic [A_W-1:0] a_q;
  logic [N_W-1:0] n_base;
  logic [N_W-1:0] n_load;
  logic [N_W-1:0] pos_nx;
  logic [A_W-1:0] a_nx;

  always_comb begin
    n_base = N_W'(clamp_range(32'(cfg_n), N_MIN, N_MAX));
    n_load = n_base + N_W'(carry_i);
    tc_o   = (pos_q == (n_q - N_W'(1)));
    pos_nx = tc_o ? '0 : (pos_q + N_W'(1));
    a_nx   = tc_o ? cfg_a : a_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      n_q     <= n_base;
      a_q     <= cfg_a;
      mod5_o  <= (cfg_a != '0);
      pulse_o <= 1'b0;
    end else begin
      pos_q   <= pos_nx;
      pulse_o <= tc_o;
      mod5_o  <= (pos_nx < {{PAD_W{1'b0}}, a_nx});
      if (tc_o) begin
        n_q <= n_load;
        a_q <= cfg_a;
      end
    end
  end

  AST_POS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pos_q < n_q); // R3
  AST_N_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (32'(n_q) >= N_MIN) && (32'(n_q) <= N_MAX + 1)); // R4
  AST_MOD_AT_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (mod5_o == (a_q != '0))); // R5
  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tc_o |=> ($stable(n_q) && $stable(a_q))); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R3

endmodule

// File: rtl/fracn_divider_chain.sv
module fracn_divider_chain #(
  parameter int R_W   = 8,
  parameter int R_MAX = 128,
  parameter int N_W   = 10,
  parameter int N_MIN = 3,
  parameter int N_MAX = 1022,
  parameter int A_W   = 2,
  parameter int F_W   = 8
) (
  input  logic           ref_clk,
  input  logic           fb_clk,
  input  logic           rst,
  input  logic [R_W-1:0] cfg_r,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic [F_W-1:0] cfg_frac,
  output logic           ref_pulse_o,
  output logic           fb_pulse_o,
  output logic           mod5_o
);

  logic main_tc;
  logic frac_carry;

  fracn_ref_div #(.R_W(R_W), .R_MAX(R_MAX)) ref_div_i (
    .clk     (ref_clk),
    .rst     (rst),
    .cfg_r   (cfg_r),
    .pulse_o (ref_pulse_o)
  );

  fracn_frac_acc #(.F_W(F_W)) frac_acc_i (
    .clk     (fb_clk),
    .rst     (rst),
    .step_i  (main_tc),
    .frac_i  (cfg_frac),
    .carry_o (frac_carry)
  );

  fracn_main_div #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) main_div_i (
    .clk     (fb_clk),
    .rst     (rst),
    .cfg_n   (cfg_n),
    .cfg_a   (cfg_a),
    .carry_i (frac_carry),
    .tc_o    (main_tc),
    .pulse_o (fb_pulse_o),
    .mod5_o  (mod5_o)
  );

endmodule

// File: tb/fracn_divider_chain_tb_top.sv
module fracn_divider_chain_tb_top;

  localparam int FW = 4;

  logic          ref_clk = 1'b0;
  logic          fb_clk  = 1'b0;
  logic          rst     = 1'b1;
  logic [7:0]    cfg_r   = 8'd3;
  logic [9:0]    cfg_n   = 10'd5;
  logic [1:0]    cfg_a   = 2'd2;
  logic [FW-1:0] cfg_frac = '0;
  logic          ref_pulse_o, fb_pulse_o, mod5_o;

  int checks = 0;
  int errors = 0;

  fracn_divider_chain #(.F_W(FW)) dut_i (
    .ref_clk(ref_clk), .fb_clk(fb_clk), .rst(rst),
    .cfg_r(cfg_r), .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_frac(cfg_frac),
    .ref_pulse_o(ref_pulse_o), .fb_pulse_o(fb_pulse_o), .mod5_o(mod5_o)
  );

  always #2.5 fb_clk = ~fb_clk;
  initial begin
    #1.3;
    forever #2.5 ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_fb();
    int guard = 0;
    @(negedge fb_clk);
    while (!fb_pulse_o && guard < 5000) begin
      @(negedge fb_clk);
      guard++;
    end
  endtask

  task automatic sync_ref();
    int guard = 0;
    @(negedge ref_clk);
    while (!ref_pulse_o && guard < 5000) begin
      @(negedge ref_clk);
      guard++;
    end
  endtask

  // Starts at a negedge where fb_pulse_o is high; ends at the next such one.
  task automatic meas_fb(input int a_exp, output int per, output int m5, output int badpos);
    int idx = 0;
    m5 = 0;
    badpos = 0;
    do begin
      if (mod5_o) m5++;
      if (mod5_o !== (idx < a_exp)) badpos++;
      @(negedge fb_clk);
      idx++;
    end while (!fb_pulse_o && idx < 5000);
    per = idx;
  endtask

  task automatic meas_ref(output int per);
    int idx = 0;
    do begin
      @(negedge ref_clk);
      idx++;
    end while (!ref_pulse_o && idx < 5000);
    per = idx;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, m5, bad, sum, odd;
    int r_vals[7] = '{0, 1, 2, 7, 128, 129, 255};
    int n_vals[8] = '{3, 4, 6, 11, 0, 2, 1022, 1023};

    // R8: reset state
    repeat (6) @(negedge fb_clk);
    chk(ref_pulse_o == 1'b0 && fb_pulse_o == 1'b0, "R8 pulses low in reset",
        int'(ref_pulse_o) + int'(fb_pulse_o), 0);
    rst = 1'b0;
    chk(mod5_o == 1'b1, "R8 mod5 first clock", int'(mod5_o), 1);
    meas_fb(2, per, m5, bad);
    chk(per == 5, "R8 first fb pulse", per, 5);

    // R1 / R2: reference divider sweep
    foreach (r_vals[i]) begin
      int expv;
      @(negedge ref_clk);
      cfg_r = 8'(r_vals[i]);
      expv = (r_vals[i] > 128 ? 128 : r_vals[i]) + 1;
      sync_ref();
      meas_ref(per);
      meas_ref(per);
      if (r_vals[i] > 128) chk(per == expv, "R2 ref clamp", per, expv);
      else                 chk(per == expv, "R1 ref period", per, expv);
    end

    // R7: reference change completes the running period
    @(negedge ref_clk);
    cfg_r = 8'd9;
    sync_ref();
    meas_ref(per);
    cfg_r = 8'd4;
    meas_ref(per);
    chk(per == 10, "R7 ref old period kept", per, 10);
    meas_ref(per);
    chk(per == 5, "R7 ref new period", per, 5);

    // R3 / R4: main divider sweep with no fraction, no swallow
    @(negedge fb_clk);
    cfg_a = 2'd0;
    cfg_frac = '0;
    foreach (n_vals[i]) begin
      int expv;
      @(negedge fb_clk);
      cfg_n = 10'(n_vals[i]);
      expv = n_vals[i] < 3 ? 3 : (n_vals[i] > 1022 ? 1022 : n_vals[i]);
      sync_fb();
      meas_fb(0, per, m5, bad);
      meas_fb(0, per, m5, bad);
      if (n_vals[i] < 3 || n_vals[i] > 1022) chk(per == expv, "R4 main clamp", per, expv);
      else                                   chk(per == expv, "R3 main period", per, expv);
    end

    // R5: swallow count sweep
    for (int a = 0; a < 4; a++) begin
      @(negedge fb_clk);
      cfg_n = 10'd6;
      cfg_a = 2'(a);
      sync_fb();
      meas_fb(a, per, m5, bad);
      meas_fb(a, per, m5, bad);
      chk(m5 == a && bad == 0, "R5 swallow count", m5, a);
      chk(4 * per + m5 == 24 + a, "R5 total ratio", 4 * per + m5, 24 + a);
    end
    @(negedge fb_clk);
    cfg_n = 10'd3;
    cfg_a = 2'd3;
    sync_fb();
    meas_fb(3, per, m5, bad);
    meas_fb(3, per, m5, bad);
    chk(m5 == 3 && bad == 0 && per == 3, "R5 swallow fills N=3", m5, 3);

    // R6: full sweep of the fractional word
    for (int f = 0; f < 16; f++) begin
      @(negedge fb_clk);
      cfg_n = 10'd5;
      cfg_a = 2'd1;
      cfg_frac = FW'(f);
      sync_fb();
      meas_fb(1, per, m5, bad);
      meas_fb(1, per, m5, bad);
      sum = 0;
      odd = 0;
      for (int k = 0; k < 16; k++) begin
        meas_fb(1, per, m5, bad);
        sum += per;
        if (per != 5 && per != 6) odd++;
        if (bad != 0) odd++;
      end
      chk(sum == 80 + f, "R6 fractional sum", sum, 80 + f);
      chk(odd == 0, "R6 period set N or N+1", odd, 0);
    end

    // R7: main divider change completes the running period
    @(negedge fb_clk);
    cfg_frac = '0;
    cfg_a = 2'd0;
    cfg_n = 10'd8;
    sync_fb();
    meas_fb(0, per, m5, bad);
    meas_fb(0, per, m5, bad);
    cfg_n = 10'd4;
    cfg_a = 2'd2;
    meas_fb(0, per, m5, bad);
    chk(per == 8 && m5 == 0, "R7 main old period kept", per, 8);
    meas_fb(2, per, m5, bad);
    chk(per == 4 && m5 == 2, "R7 main new period", per, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule